// File: doc/BRIEF.md
# Serial EEPROM Page Write Controller

This block is the write side of a serial EEPROM. It sits behind a front end that already turns the serial wires into byte events. That front end delivers start, stop and byte-received strobes to this block. The block checks the device select byte and then takes the memory address byte. It then gathers the data bytes into a 16-byte staging buffer. The write position wraps inside one 16-byte page, and the page itself never changes. When more than 16 bytes arrive, later bytes overwrite earlier ones.

A stop condition closes the transaction. The block then decides whether to commit it. A commit needs the volatile write-enable latch to be set, and it must pass the address region rules:

- The control page 80h–8Fh accepts only single-byte writes.
- At address 81h, a block of exactly four bytes is required.
- Address FFh is redirected to the top page 100h–10Fh.
- A single-byte write to 86h sets or clears the write-enable latch itself.

A committed transaction opens a timed write cycle. During that cycle the staged bytes are copied into a 272-byte array model and `busy` is held high. While `busy` is high, every bus event is ignored, and each received byte produces a NACK request. A separate read port lets the array contents be observed.

Top module: `eeprom_page_writer`

## Requirements
- R1: A transaction proceeds only if its device select byte has 1010 in bits 7:4 and 0 in bit 0. Any other device select byte makes the controller ignore all bytes until the next start.
- R2: The write-enable latch is cleared by reset and changes only as follows:
  - A single-byte write to address 86h loads the latch from data bit 1. This takes effect at stop, with no busy period and no array change.
  - Array bytes are committed only while the latch is set.
  - The latch is cleared when each write cycle ends.
- R3: Each data byte is stored at the current in-page offset, and the offset then advances modulo 16 while the page stays fixed. For example, 12 bytes sent from address 2Bh land at 2Bh–2Fh and then 20h–26h.
- R4: When more than 16 data bytes are sent, each offset keeps the last byte written to it.
- R5: A stop that commits sets `busy` from the next clock edge for exactly WR_CYCLES cycles. After those cycles, the array holds the staged bytes.
- R6: While `busy` is high, start, stop and byte strobes have no effect. Each byte strobe seen while `busy` is high raises `nack_req` for one cycle on the next edge, and `nack_req` is low otherwise.
- R7: A write to the page 80h–8Fh with more than one data byte is discarded at stop, with no busy period and no array change. The only exception is the R10 block at 81h.
- R8: A single-byte write to 80h or to 85h, 87h–8Fh is committed. A single-byte write to 81h–84h is discarded.
- R9: A write whose address byte is FFh starts at 100h and wraps within 100h–10Fh.
- R10: Address byte 81h followed by exactly four data bytes commits them to 81h–84h. Any other count at 81h is discarded.
- R11: After reset, `busy` and `nack_req` are low, the array reads 00h everywhere and the latch is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | Start condition strobe from the front end |
| bus_stop | input | 1 | Stop condition strobe from the front end |
| byte_valid | input | 1 | A received byte is present on byte_data |
| byte_data | input | 8 | Received byte |
| rd_addr | input | 9 | Array read address |
| rd_data | output | 8 | Array byte at rd_addr, one cycle later |
| busy | output | 1 | Internal write cycle in progress |
| nack_req | output | 1 | Request to NACK the byte just received |

## Verification
Two events can land in the same cycle: the end of a write cycle and a new start condition. A start that arrives in the final `busy` cycle must still be ignored, even though `busy` drops on that very edge. The bench drives the start exactly WR_CYCLES−1 cycles after the stop has been taken. It then sends, with no new start, the bytes of a latch-setting write followed by a stop. Next comes a proper write that would commit only if that latch write had been honoured. If that write shows no `busy` period and the array is unchanged, the start was correctly dropped.

// File: rtl/wp_pkg.sv
package wp_pkg;
    localparam int PAGE_BYTES = 16;
    localparam int OFF_W      = $clog2(PAGE_BYTES);
    localparam int NUM_PAGES  = 17;
    localparam int PAGE_W     = $clog2(NUM_PAGES);
    localparam int ARR_BYTES  = NUM_PAGES * PAGE_BYTES;
    localparam int ARR_AW     = PAGE_W + OFF_W;
    localparam int CNT_W      = OFF_W + 1;

    localparam logic [3:0] DEV_TAG        = 4'b1010;
    localparam logic [3:0] CTRL_PAGE      = 4'h8;
    localparam logic [7:0] ADDR_REDIRECT  = 8'hFF;
    localparam logic [7:0] ADDR_CTRL_BLK  = 8'h81;
    localparam logic [7:0] ADDR_CTRL_END  = 8'h84;
    localparam logic [7:0] ADDR_LATCH     = 8'h86;
    localparam int         CTRL_BLK_LEN   = 4;
    localparam int         LATCH_BIT      = 1;

    typedef enum logic [2:0] {ST_IDLE, ST_DEV, ST_ADDR, ST_DATA, ST_SKIP} wp_state_e;
    typedef enum logic [1:0] {V_DROP, V_LATCH, V_COMMIT} wp_verdict_e;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0]  off;
    } wp_loc_t;

    function automatic wp_loc_t start_loc(input logic [7:0] a);
        wp_loc_t l;
        if (a == ADDR_REDIRECT) begin
            l.page = PAGE_W'(NUM_PAGES - 1);
            l.off  = '0;
        end else begin
            l.page = PAGE_W'(a[7:4]);
            l.off  = a[OFF_W-1:0];
        end
        return l;
    endfunction

    // Region rules applied at stop; n saturates, so overflowed counts stay > 4.
    function automatic wp_verdict_e judge(input logic [7:0] a, input logic [CNT_W-1:0] n);
        if (a == ADDR_REDIRECT || a[7:4] != CTRL_PAGE) return V_COMMIT;
        if (a == ADDR_CTRL_BLK) return (n == CNT_W'(CTRL_BLK_LEN)) ? V_COMMIT : V_DROP;
        if (n != CNT_W'(1)) return V_DROP;
        if (a == ADDR_LATCH) return V_LATCH;
        if (a > ADDR_CTRL_BLK && a <= ADDR_CTRL_END) return V_DROP;
        return V_COMMIT;
    endfunction
endpackage

// File: rtl/wp_page_buf.sv
module wp_page_buf import wp_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             we,
    input  logic [OFF_W-1:0] widx,
    input  logic [7:0]       wdata,
    input  logic [OFF_W-1:0] ridx,
    output logic             rvalid,
    output logic [7:0]       rdata
);
    logic [7:0]            slot_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            for (int i = 0; i < PAGE_BYTES; i++) slot_q[i] <= '0;
        end else if (clr) begin
            vld_q <= '0;
        end else if (we) begin
            slot_q[widx] <= wdata;
            vld_q[widx]  <= 1'b1;
        end
    end

    assign rvalid = vld_q[ridx];
    assign rdata  = slot_q[ridx];
endmodule

// File: rtl/wp_cycle_timer.sv
module wp_cycle_timer import wp_pkg::*; #(
    parameter int WR_CYCLES = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    output logic             busy,
    output logic             last,
    output logic             in_page,
    output logic [OFF_W-1:0] idx
);
    localparam int CW = $clog2(WR_CYCLES) + 1;

    logic [CW-1:0] cnt_q;
    logic          busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (go) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (cnt_q == CW'(WR_CYCLES - 1)) busy_q <= 1'b0;
            else                             cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign busy    = busy_q;
    assign last    = busy_q && (cnt_q == CW'(WR_CYCLES - 1));
    assign in_page = cnt_q < CW'(PAGE_BYTES);
    assign idx     = cnt_q[OFF_W-1:0];

    // R5: the count never leaves the cycle window while busy
    p_busy_bound_r5: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cnt_q < CW'(WR_CYCLES)));
    // R5: a launch always yields busy on the next edge
    p_go_busy_r5: assert property (@(posedge clk) disable iff (rst)
        go |=> busy_q);
endmodule

// File: rtl/wp_nv_array.sv
module wp_nv_array import wp_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ARR_AW-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ARR_AW-1:0] raddr,
    output logic [7:0]        rdata
);
    logic [7:0] mem_q [ARR_BYTES];
    logic [7:0] rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ARR_BYTES; i++) mem_q[i] <= '0;
            rd_q <= '0;
        end else begin
            if (we && waddr < ARR_AW'(ARR_BYTES)) mem_q[waddr] <= wdata;
            rd_q <= (raddr < ARR_AW'(ARR_BYTES)) ? mem_q[raddr] : 8'h00;
        end
    end

    assign rdata = rd_q;
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer import wp_pkg::*; #(
    parameter int WR_CYCLES = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_start,
    input  logic       bus_stop,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    input  logic [8:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       busy,
    output logic       nack_req
);
    wp_state_e          state_q;
    logic [7:0]         addr_q, last_q;
    wp_loc_t            loc_q;
    logic [CNT_W-1:0]   nbytes_q;
    logic               wel_q, nack_q;

    logic               wc_last, wc_in_page;
    logic [OFF_W-1:0]   wc_idx;
    logic               buf_vld;
    logic [7:0]         buf_rd;
    wp_verdict_e        verdict;
    logic               take_stop, take_byte, commit_go, buf_clr, buf_we, arr_we;

    assign take_stop = !busy && !bus_start && bus_stop;
    assign take_byte = !busy && !bus_start && !bus_stop && byte_valid;
    assign verdict   = judge(addr_q, nbytes_q);
    assign commit_go = take_stop && state_q == ST_DATA && nbytes_q != '0
                       && verdict == V_COMMIT && wel_q;
    assign buf_clr   = take_byte && state_q == ST_ADDR;
    assign buf_we    = take_byte && state_q == ST_DATA;
    assign arr_we    = busy && wc_in_page && buf_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            addr_q   <= '0;
            last_q   <= '0;
            loc_q    <= '0;
            nbytes_q <= '0;
            wel_q    <= 1'b0;
            nack_q   <= 1'b0;
        end else begin
            nack_q <= byte_valid && busy;
            if (wc_last) wel_q <= 1'b0;
            if (!busy) begin
                if (bus_start) begin
                    state_q <= ST_DEV;
                end else if (bus_stop) begin
                    state_q <= ST_IDLE;
                    if (state_q == ST_DATA && nbytes_q != '0 && verdict == V_LATCH)
                        wel_q <= last_q[LATCH_BIT];
                end else if (byte_valid) begin
                    case (state_q)
                        ST_DEV:  state_q <= (byte_data[7:4] == DEV_TAG && !byte_data[0])
                                            ? ST_ADDR : ST_SKIP;
                        ST_ADDR: begin
                            addr_q   <= byte_data;
                            loc_q    <= start_loc(byte_data);
                            nbytes_q <= '0;
                            state_q  <= ST_DATA;
                        end
                        ST_DATA: begin
                            loc_q.off <= loc_q.off + 1'b1;
                            last_q    <= byte_data;
                            if (nbytes_q != '1) nbytes_q <= nbytes_q + 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    wp_page_buf u_buf (
        .clk(clk), .rst(rst), .clr(buf_clr), .we(buf_we),
        .widx(loc_q.off), .wdata(byte_data),
        .ridx(wc_idx), .rvalid(buf_vld), .rdata(buf_rd)
    );

    wp_cycle_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .go(commit_go), .busy(busy),
        .last(wc_last), .in_page(wc_in_page), .idx(wc_idx)
    );

    wp_nv_array u_arr (
        .clk(clk), .rst(rst), .we(arr_we),
        .waddr({loc_q.page, wc_idx}), .wdata(buf_rd),
        .raddr(rd_addr), .rdata(rd_data)
    );

    assign nack_req = nack_q;

    // R6: a byte during busy is answered with a NACK request
    p_nack_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && busy) |=> nack_req);
    // R6: no NACK request without a byte during busy
    p_nack_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !(byte_valid && busy) |=> !nack_req);
    // R2: the latch is gone once a write cycle has ended
    p_wel_clear_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !wel_q);
    // R2: a write cycle only starts with the latch set
    p_wel_needed_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wel_q));
    // R7: a discarded transaction never opens a write cycle
    p_drop_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (take_stop && state_q == ST_DATA && verdict == V_DROP) |=> !busy);
    // R3: the page stays fixed while data bytes are stored
    p_page_hold_r3: assert property (@(posedge clk) disable iff (rst)
        buf_we |=> (loc_q.page == $past(loc_q.page)));
endmodule

// File: tb/sim_eeprom_page_writer.sv
module sim_eeprom_page_writer;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 20;
    localparam int DEPTH      = 272;

    typedef struct packed {
        logic [7:0] addr;
        logic [4:0] n;
        logic [7:0] d0;
        logic       commit;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{8'h10, 5'd1,  8'h11, 1'b1, 4'd5},   // R5 plain byte write
        '{8'h2B, 5'd12, 8'h40, 1'b1, 4'd3},   // R3 wrap example
        '{8'h35, 5'd20, 8'h60, 1'b1, 4'd4},   // R4 overflow overwrite
        '{8'hFF, 5'd3,  8'h90, 1'b1, 4'd9},   // R9 redirect
        '{8'h80, 5'd1,  8'hA0, 1'b1, 4'd8},   // R8 single at 80h
        '{8'h8F, 5'd1,  8'hA5, 1'b1, 4'd8},   // R8 single at 8Fh
        '{8'h81, 5'd4,  8'hB0, 1'b1, 4'd10},  // R10 four-byte block
        '{8'h81, 5'd3,  8'hC0, 1'b0, 4'd10},  // R10 short block
        '{8'h81, 5'd5,  8'hC8, 1'b0, 4'd10},  // R10 long block
        '{8'h88, 5'd2,  8'hD0, 1'b0, 4'd7},   // R7 page write in control page
        '{8'h80, 5'd2,  8'hD8, 1'b0, 4'd7},   // R7
        '{8'h83, 5'd1,  8'hE0, 1'b0, 4'd8},   // R8 single inside 81h-84h
        '{8'h0F, 5'd2,  8'hF0, 1'b1, 4'd3}    // R3 wrap at end of page
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_start = 1'b0, bus_stop = 1'b0, byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic [8:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       busy, nack_req;

    int n_checks = 0;
    int n_errors = 0;
    logic [7:0] model [DEPTH];

    eeprom_page_writer #(.WR_CYCLES(W)) u0 (
        .clk(clk), .rst(rst), .bus_start(bus_start), .bus_stop(bus_stop),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .nack_req(nack_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick_start();
        @(negedge clk); bus_start = 1'b1;
        @(negedge clk); bus_start = 1'b0;
    endtask

    task automatic tick_stop();
        @(negedge clk); bus_stop = 1'b1;
        @(negedge clk); bus_stop = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit look, input bit exp_nack);
        @(negedge clk); byte_valid = 1'b1; byte_data = b;
        @(negedge clk); byte_valid = 1'b0;
        if (look) chk(nack_req == exp_nack, "R6 nack", int'(nack_req), int'(exp_nack));
    endtask

    task automatic txn(input logic [7:0] dev, input logic [7:0] a, input int n, input logic [7:0] d0);
        tick_start();
        send_byte(dev, 1'b0, 1'b0);
        send_byte(a, 1'b0, 1'b0);
        for (int i = 0; i < n; i++) send_byte(d0 + 8'(i), 1'b0, 1'b0);
        tick_stop();
    endtask

    task automatic busy_len(output int len);
        len = 0;
        while (busy && len < 200) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic set_wel(input bit v);
        txn(8'hA0, 8'h86, 1, v ? 8'h02 : 8'h00);
    endtask

    task automatic model_write(input logic [7:0] a, input int n, input logic [7:0] d0);
        int page, off;
        page = (a == 8'hFF) ? 16 : int'(a[7:4]);
        off  = (a == 8'hFF) ? 0 : int'(a[3:0]);
        for (int i = 0; i < n; i++) begin
            model[page*16 + off] = d0 + 8'(i);
            off = (off + 1) % 16;
        end
    endtask

    task automatic verify_array(input string req);
        int mism = 0;
        int bad_a = 0, bad_v = 0, bad_e = 0;
        @(negedge clk); rd_addr = '0;
        @(negedge clk);
        for (int a = 0; a < DEPTH; a++) begin
            if (rd_data !== model[a]) begin
                if (mism == 0) begin bad_a = a; bad_v = int'(rd_data); bad_e = int'(model[a]); end
                mism++;
            end
            rd_addr = 9'(a + 1);
            @(negedge clk);
        end
        chk(mism == 0, req, bad_v, bad_e);
        if (mism != 0) $display("  first mismatch at %0h, %0d in total", bad_a, mism);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
        report();
    end

    initial begin
        int len;
        for (int a = 0; a < DEPTH; a++) model[a] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R11 reset state
        chk(busy == 1'b0, "R11 busy", int'(busy), 0);
        chk(nack_req == 1'b0, "R11 nack", int'(nack_req), 0);
        verify_array("R11 array");
        txn(8'hA0, 8'h20, 1, 8'h33);
        busy_len(len);
        chk(len == 0, "R11 latch clear", len, 0);

        // R2 latch behaviour
        set_wel(1'b1);
        busy_len(len);
        chk(len == 0, "R2 latch write no busy", len, 0);
        txn(8'hA0, 8'h20, 1, 8'h34);
        busy_len(len);
        chk(len == W, "R2 commit with latch", len, W);
        model_write(8'h20, 1, 8'h34);
        txn(8'hA0, 8'h21, 1, 8'h35);
        busy_len(len);
        chk(len == 0, "R2 latch cleared after cycle", len, 0);
        set_wel(1'b1);
        set_wel(1'b0);
        txn(8'hA0, 8'h21, 1, 8'h36);
        busy_len(len);
        chk(len == 0, "R2 latch cleared by bit1=0", len, 0);
        verify_array("R2 array");

        // R1 device select
        set_wel(1'b1);
        txn(8'hA1, 8'h22, 1, 8'h44);
        busy_len(len);
        chk(len == 0, "R1 read bit set", len, 0);
        txn(8'hB0, 8'h22, 1, 8'h45);
        busy_len(len);
        chk(len == 0, "R1 wrong tag", len, 0);
        txn(8'hA0, 8'h22, 1, 8'h46);
        busy_len(len);
        chk(len == W, "R1 good select", len, W);
        model_write(8'h22, 1, 8'h46);
        verify_array("R1 array");

        // table of region and wrap cases (R3 R4 R5 R7 R8 R9 R10)
        for (int v = 0; v < NV; v++) begin
            set_wel(1'b1);
            txn(8'hA0, VECS[v].addr, int'(VECS[v].n), VECS[v].d0);
            busy_len(len);
            chk(len == (VECS[v].commit ? W : 0), $sformatf("R%0d vector %0d busy", VECS[v].req, v),
                len, VECS[v].commit ? W : 0);
            if (VECS[v].commit) model_write(VECS[v].addr, int'(VECS[v].n), VECS[v].d0);
            verify_array($sformatf("R%0d vector %0d array", VECS[v].req, v));
        end

        // R6 bus activity during busy is ignored and NACKed
        set_wel(1'b1);
        txn(8'hA0, 8'h50, 2, 8'h70);
        model_write(8'h50, 2, 8'h70);
        chk(busy == 1'b1, "R5 busy after stop", int'(busy), 1);
        tick_start();
        send_byte(8'hA0, 1'b1, 1'b1);
        send_byte(8'h60, 1'b1, 1'b1);
        send_byte(8'h77, 1'b1, 1'b1);
        tick_stop();
        busy_len(len);
        @(negedge clk);
        chk(nack_req == 1'b0, "R6 nack low after busy", int'(nack_req), 0);
        busy_len(len);
        chk(len == 0, "R6 no second cycle", len, 0);
        verify_array("R6 array");

        // same cycle: start during last busy cycle must be dropped (R5, R6)
        set_wel(1'b1);
        txn(8'hA0, 8'h51, 1, 8'h7A);
        model_write(8'h51, 1, 8'h7A);
        repeat (W - 1) @(negedge clk);
        chk(busy == 1'b1, "R5 last busy cycle", int'(busy), 1);
        bus_start = 1'b1;
        @(negedge clk); bus_start = 1'b0;
        chk(busy == 1'b0, "R5 busy length", int'(busy), 0);
        send_byte(8'hA0, 1'b0, 1'b0);
        send_byte(8'h86, 1'b0, 1'b0);
        send_byte(8'h02, 1'b0, 1'b0);
        tick_stop();
        txn(8'hA0, 8'h52, 1, 8'h7B);
        busy_len(len);
        chk(len == 0, "R6 start in last busy cycle ignored", len, 0);
        verify_array("R6 array after edge case");

        report();
    end
endmodule